// File: doc/BRIEF.md
# Row-Granular Detection-Code Cache

This block is a small direct-mapped cache, placed in front of one memory channel, that keeps recently used error-detection codes close to the controller. Every data row of 2 KB carries 32 lines, and each line is protected by one code byte. A cache entry holds the 32 code bytes of one whole data row. The first touch of any line in a row therefore brings in the codes for the row's other 31 lines as well.

A requester presents a data row number, a bank number and a line position inside the row. A read that hits returns the code byte one cycle after it is accepted. A read that misses raises a fill request for that row and bank, and stops accepting new requests. When the 32-byte fill returns, the block overwrites the entry at that index and returns the requested byte. A write request carries a new code byte. If its row is present, the byte is replaced in place. If its row is absent, the write is dropped and nothing is allocated. The entry index is the low six bits of the row number. The stored tag joins the remaining nine row bits with the three bank bits.

Top module: `dcc_cache`

## Requirements
- R1: After reset every entry is invalid, `req_ready` is 1, and `rsp_valid` and `fill_req_valid` are 0.
- R2: A read accepted (`req_valid` and `req_ready` high, `req_write` low) whose row and bank match a valid entry gives `rsp_valid`=1 on the next cycle, with `rsp_code` equal to byte `req_line` of that entry. Byte k occupies bits 8k+7..8k.
- R3: A read that misses gives `rsp_valid`=0 on the next cycle and raises `fill_req_valid`, with `fill_req_row` and `fill_req_bank` equal to the requested row and bank. The fill request is held steady until a cycle with `fill_valid` high.
- R4: In a cycle where a fill is pending and `fill_valid` is high, the 256-bit `fill_data` is installed. On the next cycle `rsp_valid`=1, `rsp_code` is byte `req_line` of `fill_data`, and later reads to any line of that row and bank hit.
- R5: `req_ready` is 0 from the cycle after a missing read is accepted until the cycle after its fill arrives. It is 1 again from that cycle on.
- R6: The tag includes the bank. The same row number in a different bank misses.
- R7: The index is row bits 5..0. A fill replaces whatever entry was at that index, so a row that differs only in bits 14..6, or a different bank at the same index, evicts the earlier row, and that earlier row then misses.
- R8: An accepted write (`req_write`=1) that hits replaces only byte `req_line` of the entry with `req_wcode`. It produces no response, and the other bytes are unchanged.
- R9: An accepted write that misses does nothing. There is no response and no fill request, `req_ready` stays 1, and a later read of that row misses.
- R10: Rows whose indices differ are held at the same time, and both hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted (no fill pending) |
| req_write | input | 1 | 1 = code update, 0 = code lookup |
| req_row | input | 15 | Data row number |
| req_bank | input | 3 | Bank number |
| req_line | input | 5 | Line position inside the row |
| req_wcode | input | 8 | New code byte for a write |
| rsp_valid | output | 1 | Lookup result valid (one-cycle pulse) |
| rsp_code | output | 8 | Code byte returned |
| fill_req_valid | output | 1 | Fill of a code row segment requested |
| fill_req_row | output | 15 | Row of the requested segment |
| fill_req_bank | output | 3 | Bank of the requested segment |
| fill_valid | input | 1 | Fill data present |
| fill_data | input | 256 | 32 code bytes of the row, byte k for line k |

## Verification
The assertions take for granted that `fill_valid` is raised only while `fill_req_valid` is high and that request fields are known whenever `req_valid` is high. Under those conditions a missing read always leads to exactly one fill handshake, followed by one response. The bench raises `fill_valid` only after it has seen the fill request and checked the request's row and bank. It drops `fill_valid` right after the installing edge and drives requests only while `req_ready` is high. So every accepted request is one whose outcome, hit or miss, the bench has already predicted.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } dcc_state_e;
endpackage

// File: rtl/dcc_tag_store.sv
module dcc_tag_store #(
  parameter int IDX_W = 6,
  parameter int TAG_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             hit,
  input  logic             inst_en,
  input  logic [IDX_W-1:0] inst_idx,
  input  logic [TAG_W-1:0] inst_tag
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [ENTRIES-1:0] vld_q, vld_nxt;
  logic [TAG_W-1:0]   tags_q [ENTRIES];

  always_comb begin
    vld_nxt = vld_q;
    if (inst_en) vld_nxt[inst_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_nxt;
  end

  always_ff @(posedge clk) begin
    if (inst_en) tags_q[inst_idx] <= inst_tag;
  end

  assign hit = vld_q[lk_idx] && (tags_q[lk_idx] == lk_tag);

  // R4: an installed entry is valid and carries the new tag afterwards
  p_install_sets_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    inst_en |=> (vld_q[$past(inst_idx)] && (tags_q[$past(inst_idx)] == $past(inst_tag))));
endmodule

// File: rtl/dcc_data_store.sv
module dcc_data_store #(
  parameter int IDX_W  = 6,
  parameter int LINE_W = 5,
  parameter int CODE_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [IDX_W-1:0]             rd_idx,
  input  logic [LINE_W-1:0]            rd_line,
  output logic [CODE_W-1:0]            rd_code,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic                         byte_we,
  input  logic [LINE_W-1:0]            wr_line,
  input  logic [CODE_W-1:0]            wr_code,
  input  logic                         line_we,
  input  logic [(CODE_W<<LINE_W)-1:0]  line_data
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int LINES   = 1 << LINE_W;
  localparam int ENTRY_W = CODE_W * LINES;

  logic [ENTRY_W-1:0] mem_q [ENTRIES];
  logic [ENTRY_W-1:0] rd_entry;
  logic [CODE_W-1:0]  rd_bytes [LINES];

  assign rd_entry = mem_q[rd_idx];

  for (genvar g = 0; g < LINES; g++) begin : g_byte
    assign rd_bytes[g] = rd_entry[g*CODE_W +: CODE_W];
  end

  assign rd_code = rd_bytes[rd_line];

  always_ff @(posedge clk) begin
    if (line_we)      mem_q[wr_idx] <= line_data;
    else if (byte_we) mem_q[wr_idx][wr_line*CODE_W +: CODE_W] <= wr_code;
  end

  // R8: an in-place byte update lands in the addressed byte
  p_byte_write_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_we && !line_we) |=>
      (mem_q[$past(wr_idx)][$past(wr_line)*CODE_W +: CODE_W] == $past(wr_code)));
endmodule

// File: rtl/dcc_ctrl.sv
module dcc_ctrl
  import dcc_pkg::*;
#(
  parameter int ROW_W  = 15,
  parameter int BANK_W = 3,
  parameter int LINE_W = 5,
  parameter int CODE_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic                         req_write,
  input  logic [ROW_W-1:0]             req_row,
  input  logic [BANK_W-1:0]            req_bank,
  input  logic [LINE_W-1:0]            req_line,
  input  logic                         hit,
  input  logic [CODE_W-1:0]            hit_code,
  input  logic                         fill_valid,
  input  logic [(CODE_W<<LINE_W)-1:0]  fill_data,
  output logic                         req_ready,
  output logic                         rsp_valid,
  output logic [CODE_W-1:0]            rsp_code,
  output logic                         fill_pending,
  output logic [ROW_W-1:0]             pend_row,
  output logic [BANK_W-1:0]            pend_bank,
  output logic                         byte_we,
  output logic                         line_we
);
  dcc_state_e        state_q, state_nxt;
  logic              rsp_valid_nxt;
  logic [CODE_W-1:0] rsp_code_nxt;
  logic              pend_en;
  logic [LINE_W-1:0] pend_line;
  logic              accept;

  assign accept = req_valid && (state_q == ST_IDLE);

  always_comb begin
    state_nxt     = state_q;
    rsp_valid_nxt = 1'b0;
    rsp_code_nxt  = rsp_code;
    pend_en       = 1'b0;
    byte_we       = 1'b0;
    line_we       = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (req_write) begin
            byte_we = hit;
          end else if (hit) begin
            rsp_valid_nxt = 1'b1;
            rsp_code_nxt  = hit_code;
          end else begin
            pend_en   = 1'b1;
            state_nxt = ST_FILL;
          end
        end
      end
      ST_FILL: begin
        if (fill_valid) begin
          line_we       = 1'b1;
          rsp_valid_nxt = 1'b1;
          rsp_code_nxt  = fill_data[pend_line*CODE_W +: CODE_W];
          state_nxt     = ST_IDLE;
        end
      end
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      rsp_valid <= 1'b0;
    end else begin
      state_q   <= state_nxt;
      rsp_valid <= rsp_valid_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rsp_valid_nxt) rsp_code <= rsp_code_nxt;
    if (pend_en) begin
      pend_row  <= req_row;
      pend_bank <= req_bank;
      pend_line <= req_line;
    end
  end

  assign req_ready    = (state_q == ST_IDLE);
  assign fill_pending = (state_q == ST_FILL);
endmodule

// File: rtl/dcc_cache.sv
module dcc_cache #(
  parameter int ROW_W  = 15,
  parameter int BANK_W = 3,
  parameter int LINE_W = 5,
  parameter int IDX_W  = 6,
  parameter int CODE_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic                         req_write,
  input  logic [ROW_W-1:0]             req_row,
  input  logic [BANK_W-1:0]            req_bank,
  input  logic [LINE_W-1:0]            req_line,
  input  logic [CODE_W-1:0]            req_wcode,
  output logic                         rsp_valid,
  output logic [CODE_W-1:0]            rsp_code,
  output logic                         fill_req_valid,
  output logic [ROW_W-1:0]             fill_req_row,
  output logic [BANK_W-1:0]            fill_req_bank,
  input  logic                         fill_valid,
  input  logic [(CODE_W<<LINE_W)-1:0]  fill_data
);
  localparam int TAG_W = ROW_W - IDX_W + BANK_W;

  logic [IDX_W-1:0]  req_idx, pend_idx, wr_idx;
  logic [TAG_W-1:0]  req_tag, pend_tag;
  logic              hit, byte_we, line_we;
  logic [CODE_W-1:0] hit_code;

  assign req_idx  = req_row[IDX_W-1:0];
  assign req_tag  = {req_row[ROW_W-1:IDX_W], req_bank};
  assign pend_idx = fill_req_row[IDX_W-1:0];
  assign pend_tag = {fill_req_row[ROW_W-1:IDX_W], fill_req_bank};
  assign wr_idx   = line_we ? pend_idx : req_idx;

  dcc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .lk_idx(req_idx), .lk_tag(req_tag), .hit(hit),
    .inst_en(line_we), .inst_idx(pend_idx), .inst_tag(pend_tag)
  );

  dcc_data_store #(.IDX_W(IDX_W), .LINE_W(LINE_W), .CODE_W(CODE_W)) u_data (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(req_idx), .rd_line(req_line), .rd_code(hit_code),
    .wr_idx(wr_idx), .byte_we(byte_we), .wr_line(req_line), .wr_code(req_wcode),
    .line_we(line_we), .line_data(fill_data)
  );

  dcc_ctrl #(.ROW_W(ROW_W), .BANK_W(BANK_W), .LINE_W(LINE_W), .CODE_W(CODE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_row(req_row),
    .req_bank(req_bank), .req_line(req_line),
    .hit(hit), .hit_code(hit_code),
    .fill_valid(fill_valid), .fill_data(fill_data),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
    .fill_pending(fill_req_valid), .pend_row(fill_req_row), .pend_bank(fill_req_bank),
    .byte_we(byte_we), .line_we(line_we)
  );

  // R3: a missing lookup starts a fill and gives no response
  p_miss_starts_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write && !hit) |=> (fill_req_valid && !rsp_valid));

  // R3: the fill request holds steady until data arrives
  p_fill_req_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req_valid && !fill_valid) |=>
      (fill_req_valid && $stable(fill_req_row) && $stable(fill_req_bank)));

  // R4 and R5: the arriving fill answers and reopens the request port
  p_fill_responds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req_valid && fill_valid) |=> (rsp_valid && req_ready && !fill_req_valid));

  // R9: an accepted write never answers and never fetches
  p_write_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write) |=> (!rsp_valid && !fill_req_valid));

  // R2: a hitting lookup answers on the next cycle
  p_hit_answers_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write && hit) |=> (rsp_valid && req_ready));
endmodule

// File: tb/test_dcc_cache.sv
`timescale 1ns/1ps
module test_dcc_cache;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid, req_write;
  logic         req_ready;
  logic [14:0]  req_row;
  logic [2:0]   req_bank;
  logic [4:0]   req_line;
  logic [7:0]   req_wcode;
  logic         rsp_valid;
  logic [7:0]   rsp_code;
  logic         fill_req_valid;
  logic [14:0]  fill_req_row;
  logic [2:0]   fill_req_bank;
  logic         fill_valid;
  logic [255:0] fill_data;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dcc_cache i_dcc_cache (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_row(req_row), .req_bank(req_bank), .req_line(req_line), .req_wcode(req_wcode),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code),
    .fill_req_valid(fill_req_valid), .fill_req_row(fill_req_row), .fill_req_bank(fill_req_bank),
    .fill_valid(fill_valid), .fill_data(fill_data)
  );

  function automatic logic [7:0] code_of(input logic [14:0] row, input logic [2:0] bank,
                                         input int k);
    logic [7:0] v;
    v = row[7:0] ^ {bank, 5'd0} ^ row[14:7] ^ 8'(k * 37 + 1);
    return v;
  endfunction

  function automatic logic [255:0] segment_of(input logic [14:0] row, input logic [2:0] bank);
    logic [255:0] s;
    for (int k = 0; k < 32; k++) s[k*8 +: 8] = code_of(row, bank, k);
    return s;
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
    end
  endtask

  // One lookup; a miss is served with a fill from the bench's own segment model
  task automatic do_read(input logic [14:0] row, input logic [2:0] bank, input logic [4:0] line,
                         input bit exp_hit, input logic [7:0] exp_code, input string rq);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0;
    req_row = row; req_bank = bank; req_line = line;
    @(negedge clk);
    req_valid = 1'b0;
    if (exp_hit) begin
      check(rsp_valid == 1'b1, rq, "hit rsp_valid", int'(rsp_valid), 1);
      check(rsp_code == exp_code, rq, "hit rsp_code", int'(rsp_code), int'(exp_code));
      check(fill_req_valid == 1'b0, rq, "hit no fill", int'(fill_req_valid), 0);
    end else begin
      check(rsp_valid == 1'b0, "R3", "miss rsp_valid", int'(rsp_valid), 0);
      check(fill_req_valid == 1'b1, rq, "miss fill_req_valid", int'(fill_req_valid), 1);
      check(fill_req_row == row, "R3", "fill_req_row", int'(fill_req_row), int'(row));
      check(fill_req_bank == bank, "R3", "fill_req_bank", int'(fill_req_bank), int'(bank));
      check(req_ready == 1'b0, "R5", "ready during fill", int'(req_ready), 0);
      repeat (2) begin
        @(negedge clk);
        check(req_ready == 1'b0, "R5", "ready while waiting", int'(req_ready), 0);
        check(fill_req_valid == 1'b1 && fill_req_row == row, "R3", "fill held",
              int'(fill_req_row), int'(row));
      end
      fill_valid = 1'b1;
      fill_data  = segment_of(row, bank);
      @(negedge clk);
      fill_valid = 1'b0;
      check(rsp_valid == 1'b1, "R4", "fill rsp_valid", int'(rsp_valid), 1);
      check(rsp_code == exp_code, "R4", "fill rsp_code", int'(rsp_code), int'(exp_code));
      check(req_ready == 1'b1, "R5", "ready after fill", int'(req_ready), 1);
      check(fill_req_valid == 1'b0, "R4", "fill req dropped", int'(fill_req_valid), 0);
    end
    @(negedge clk);
    check(rsp_valid == 1'b0, rq, "response is one pulse", int'(rsp_valid), 0);
  endtask

  task automatic do_write(input logic [14:0] row, input logic [2:0] bank, input logic [4:0] line,
                          input logic [7:0] code, input string rq);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1;
    req_row = row; req_bank = bank; req_line = line; req_wcode = code;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    check(rsp_valid == 1'b0, rq, "write rsp_valid", int'(rsp_valid), 0);
    check(fill_req_valid == 1'b0, rq, "write fill_req_valid", int'(fill_req_valid), 0);
    check(req_ready == 1'b1, rq, "write ready", int'(req_ready), 1);
  endtask

  task automatic t_reset;
    check(req_ready == 1'b1, "R1", "reset req_ready", int'(req_ready), 1);
    check(rsp_valid == 1'b0, "R1", "reset rsp_valid", int'(rsp_valid), 0);
    check(fill_req_valid == 1'b0, "R1", "reset fill_req_valid", int'(fill_req_valid), 0);
    do_read(15'h0000, 3'd0, 5'd0, 1'b0, code_of(15'h0000, 3'd0, 0), "R1");
  endtask

  task automatic t_cold_miss_then_hits;
    do_read(15'h0123, 3'd2, 5'd7, 1'b0, code_of(15'h0123, 3'd2, 7), "R3");
    do_read(15'h0123, 3'd2, 5'd0, 1'b1, code_of(15'h0123, 3'd2, 0), "R2");
    do_read(15'h0123, 3'd2, 5'd31, 1'b1, code_of(15'h0123, 3'd2, 31), "R2");
    do_read(15'h0123, 3'd2, 5'd7, 1'b1, code_of(15'h0123, 3'd2, 7), "R4");
  endtask

  task automatic t_bank_in_tag;
    do_read(15'h0123, 3'd5, 5'd3, 1'b0, code_of(15'h0123, 3'd5, 3), "R6");
    do_read(15'h0123, 3'd5, 5'd9, 1'b1, code_of(15'h0123, 3'd5, 9), "R6");
    do_read(15'h0123, 3'd2, 5'd1, 1'b0, code_of(15'h0123, 3'd2, 1), "R7");
  endtask

  task automatic t_index_conflict;
    do_read(15'h0163, 3'd2, 5'd4, 1'b0, code_of(15'h0163, 3'd2, 4), "R7");
    do_read(15'h4E23, 3'd2, 5'd5, 1'b0, code_of(15'h4E23, 3'd2, 5), "R7");
    do_read(15'h0163, 3'd2, 5'd4, 1'b0, code_of(15'h0163, 3'd2, 4), "R7");
  endtask

  task automatic t_distinct_indices;
    do_read(15'h0010, 3'd1, 5'd2, 1'b0, code_of(15'h0010, 3'd1, 2), "R10");
    do_read(15'h0011, 3'd1, 5'd2, 1'b0, code_of(15'h0011, 3'd1, 2), "R10");
    do_read(15'h0010, 3'd1, 5'd20, 1'b1, code_of(15'h0010, 3'd1, 20), "R10");
    do_read(15'h0011, 3'd1, 5'd21, 1'b1, code_of(15'h0011, 3'd1, 21), "R10");
  endtask

  task automatic t_write_hit;
    do_write(15'h0010, 3'd1, 5'd3, 8'hA5, "R8");
    do_read(15'h0010, 3'd1, 5'd3, 1'b1, 8'hA5, "R8");
    do_read(15'h0010, 3'd1, 5'd4, 1'b1, code_of(15'h0010, 3'd1, 4), "R8");
    do_read(15'h0010, 3'd1, 5'd2, 1'b1, code_of(15'h0010, 3'd1, 2), "R8");
    do_read(15'h0011, 3'd1, 5'd3, 1'b1, code_of(15'h0011, 3'd1, 3), "R8");
  endtask

  task automatic t_write_miss;
    do_write(15'h7F55, 3'd6, 5'd8, 8'h3C, "R9");
    do_write(15'h0410, 3'd1, 5'd3, 8'h11, "R9");
    do_read(15'h0010, 3'd1, 5'd3, 1'b1, 8'hA5, "R9");
    do_read(15'h7F55, 3'd6, 5'd8, 1'b0, code_of(15'h7F55, 3'd6, 8), "R9");
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0;
    req_row = '0; req_bank = '0; req_line = '0; req_wcode = '0;
    fill_valid = 1'b0; fill_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cold_miss_then_hits();
    t_bank_in_tag();
    t_index_conflict();
    t_distinct_indices();
    t_write_hit();
    t_write_miss();
    repeat (2) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  end
endmodule